// File: doc/BRIEF.md
# Fetch-Snooping Text Video Serializer

This block draws text on a display with very little hardware. It uses the processor's instruction stream as the source of display data. It watches the instruction-fetch bus. When video is on and a fetch comes from an address whose bit 6 is set, the low byte of the fetched instruction is taken as a character code. That code, joined with a 3-bit sub-row number, indexes a 2K x 8 glyph table. The glyph byte is loaded into a shift register, which sends one pixel per dot clock.

Software displays a text line by running through 40 consecutive instructions in the tapped address window. The low byte of each instruction is one character. With an 8 MHz dot clock and one fetch per microsecond, each fetch supplies exactly the 8 pixels of one character cell. Sync generation and the processor itself are outside this block. The glyph table is computed internally from the index.

Top module: `fetch_glyph_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first capture, `pix_out` is 0.
- R2: A character is captured only at a rising clock edge where `fetch_strobe` is 1, `vid_ctrl[0]` is 1 and `fetch_addr[6]` is 1. Any other fetch leaves the pixel stream unchanged.
- R3: The glyph index is {`fetch_data[7:0]`, `vid_ctrl[3:1]`}, with the sub-row sampled together with the fetch. For code c and sub-row r, the glyph byte is c rotated left by r places, XOR r zero-extended to 8 bits.
- R4: Pixels leave most significant bit first. For a fetch sampled at edge k, glyph bit 7 is on `pix_out` after edge k+1. Bit i is on `pix_out` after edge k+1+(7-i).
- R5: Once all eight pixels of a glyph have been sent, `pix_out` is 0 until the next load.
- R6: Qualifying fetches spaced exactly 8 clocks apart give a gapless pixel stream, for example a 40-character line.
- R7: A load that arrives while a glyph is still shifting replaces the remaining bits. The new glyph's bit 7 follows at once.
- R8: While `vid_ctrl[0]` is 0, `pix_out` is 0 in the same cycle, the shift register is emptied and a pending capture is dropped. After video is re-enabled, output stays 0 until a new capture.
- R9: `fetch_data[15:8]` and all address bits other than bit 6 have no effect on the pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock (8 MHz in the intended system) |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_strobe | input | 1 | High for one clock when an instruction fetch is on the bus |
| fetch_addr | input | 16 | Address of the fetch; bit 6 selects the display window |
| fetch_data | input | 16 | Fetched instruction word; the low byte is the character code |
| vid_ctrl | input | 4 | Control register: bit 0 video enable, bits 3:1 sub-row |
| pix_out | output | 1 | Serial pixel stream, one pixel per clock |

## Verification
A qualifying fetch presented before edge k produces its first pixel after edge k+1: one edge registers the capture, and the next loads the shifter. Its eighth pixel is produced after edge k+8. The bench drives every input and samples `pix_out` on the falling edge. For each fetch it writes the eight expected pixels into a ring of future-cycle slots starting two edges ahead. A later fetch overwrites the slots it takes over, and a disable clears the slots ahead. The bench compares the current slot on every cycle, so a pixel that is one cycle early or late, or that should be dark, is reported at once.

// File: rtl/fgs_pkg.sv
// Shared widths and the capture record for the fetch-snooping serializer.
// Assumes an 8-bit character code and a 3-bit sub-row, giving a 2K glyph index.
package fgs_pkg;
    localparam int CODE_W = 8;
    localparam int ROW_W  = 3;
    localparam int NROWS  = 1 << ROW_W;
    localparam int IDX_W  = CODE_W + ROW_W;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        logic [ROW_W-1:0]  row;
    } fgs_cap_t;

    // Glyph table index: character code in the upper bits, sub-row below.
    function automatic logic [IDX_W-1:0] glyph_index(input fgs_cap_t c);
        return {c.code, c.row};
    endfunction
endpackage

// File: rtl/fgs_fetch_tap.sv
// Fetch tap: watches the instruction-fetch bus and registers a character
// capture when video is on and the tapped address bit is set.
// Assumes fetch_strobe is high for exactly one clock per fetch.
module fgs_fetch_tap
    import fgs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int TAP_BIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_strobe,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic [INSTR_W-1:0]  fetch_data,
    input  logic                vid_en,
    input  logic [ROW_W-1:0]    sub_row,
    output fgs_cap_t            cap_q
);
    logic hit;

    // Qualify the fetch: strobe, enable and the window address bit.
    always_comb begin
        hit = fetch_strobe & vid_en & fetch_addr[TAP_BIT];
    end

    // Register the low byte and sub-row of a qualifying fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q.vld <= hit;
            if (hit) begin
                cap_q.code <= fetch_data[CODE_W-1:0];
                cap_q.row  <= sub_row;
            end
        end
    end
endmodule

// File: rtl/fgs_glyph_rom.sv
// Glyph table: 2K x 8 read-only lookup computed from its index.
// The byte for code c and sub-row r is c rotated left by r, XOR r.
// Assumes NROWS <= CODE_W, so every rotation amount is in range.
module fgs_glyph_rom
    import fgs_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [CODE_W-1:0] glyph
);
    logic [CODE_W-1:0] code;
    logic [ROW_W-1:0]  row;
    logic [CODE_W-1:0] rot [NROWS];

    // Split the index into character code and sub-row.
    always_comb begin
        code = idx[IDX_W-1:ROW_W];
        row  = idx[ROW_W-1:0];
    end

    // One rotated copy of the code per sub-row.
    generate
        for (genvar r = 0; r < NROWS; r++) begin : g_rot
            if (r == 0) begin : g_id
                assign rot[r] = code;
            end else begin : g_sh
                assign rot[r] = {code[CODE_W-1-r:0], code[CODE_W-1:CODE_W-r]};
            end
        end
    endgenerate

    // Select the row's rotation and fold the row number into the low bits.
    always_comb begin
        glyph = rot[row] ^ CODE_W'(row);
    end
endmodule

// File: rtl/fgs_dot_shifter.sv
// Dot shifter: parallel-load shift register that sends its byte MSB first,
// one bit per clock, and is dark once the byte is used up.
// Assumes load is a single-cycle pulse; a load always wins over shifting.
module fgs_dot_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         pix
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] left_q;

    // Load, shift or empty the register, counting the bits still to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (!en) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= din;
            left_q <= CNT_W'(W);
        end else if (left_q != '0) begin
            sh_q   <= {sh_q[W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    // Present the top bit only while a byte is being sent.
    always_comb begin
        pix = (left_q != '0) & sh_q[W-1];
    end
endmodule

// File: rtl/fetch_glyph_serializer.sv
// Top: fetch-snooping text video serializer. Captures character codes from
// instruction fetches in the tapped window, looks up the glyph row and
// shifts it out as pixels. Assumes clk is the dot clock and that vid_ctrl
// is held by a processor-written register (bit 0 enable, upper bits sub-row).
module fetch_glyph_serializer
    import fgs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int TAP_BIT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_strobe,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic [INSTR_W-1:0]   fetch_data,
    input  logic [ROW_W:0]       vid_ctrl,
    output logic                 pix_out
);
    logic              vid_en;
    logic [ROW_W-1:0]  sub_row;
    fgs_cap_t          cap_q;
    logic [CODE_W-1:0] glyph_byte;
    logic              shift_pix;

    // Split the control register into enable and sub-row.
    always_comb begin
        vid_en  = vid_ctrl[0];
        sub_row = vid_ctrl[ROW_W:1];
    end

    fgs_fetch_tap #(
        .ADDR_W (ADDR_W),
        .INSTR_W(INSTR_W),
        .TAP_BIT(TAP_BIT)
    ) u_tap (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_strobe(fetch_strobe),
        .fetch_addr  (fetch_addr),
        .fetch_data  (fetch_data),
        .vid_en      (vid_en),
        .sub_row     (sub_row),
        .cap_q       (cap_q)
    );

    fgs_glyph_rom u_rom (
        .idx  (glyph_index(cap_q)),
        .glyph(glyph_byte)
    );

    fgs_dot_shifter #(
        .W(CODE_W)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (vid_en),
        .load (cap_q.vld),
        .din  (glyph_byte),
        .pix  (shift_pix)
    );

    // Blank the pixel at once whenever video is switched off.
    always_comb begin
        pix_out = shift_pix & vid_en;
    end
endmodule

// File: rtl/fgs_checker.sv
// Checker for the serializer: relates the fetch bus, the capture stage,
// the glyph lookup and the pixel output over time.
module fgs_checker (
    input logic clk,
    input logic rst_n,
    input logic fetch_strobe,
    input logic fetch_tap,
    input logic vid_en,
    input logic cap_vld,
    input logic glyph_msb,
    input logic pix_out
);
    // R2
    cap_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> $past(fetch_strobe && vid_en && fetch_tap));

    // R2
    no_stray_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_strobe && vid_en && fetch_tap) |=> !cap_vld);

    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && vid_en) |=> (!vid_en || pix_out == $past(glyph_msb)));

    // R8
    dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |-> !pix_out);
endmodule

bind fetch_glyph_serializer fgs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_strobe(fetch_strobe),
    .fetch_tap   (fetch_addr[TAP_BIT]),
    .vid_en      (vid_ctrl[0]),
    .cap_vld     (cap_q.vld),
    .glyph_msb   (glyph_byte[7]),
    .pix_out     (pix_out)
);

// File: tb/fetch_glyph_serializer_bench.sv
// Bench: directed corner cases and seeded random fetch streams, checked
// cycle by cycle against a ring of expected pixels built from the requirements.
module fetch_glyph_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RING = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_strobe = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [15:0] fetch_data = '0;
    logic [3:0]  vid_ctrl = '0;
    logic        pix_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic exp_ring [RING];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetch_glyph_serializer u_fetch_glyph_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_strobe(fetch_strobe),
        .fetch_addr  (fetch_addr),
        .fetch_data  (fetch_data),
        .vid_ctrl    (vid_ctrl),
        .pix_out     (pix_out)
    );

    // R3: rotate code left by the sub-row, then XOR the sub-row.
    function automatic logic [7:0] glyph_model(input logic [7:0] c, input logic [2:0] r);
        logic [15:0] w;
        w = {c, c} << r;
        return w[15:8] ^ {5'b0, r};
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // One cycle: check the current pixel, drive the next inputs, update expectations.
    task automatic tick(input logic stb, input logic [15:0] a, input logic [15:0] d,
                        input logic [3:0] ctrl, input string tag);
        logic [7:0] g;
        @(negedge clk);
        n_tests++;
        if (pix_out !== exp_ring[cyc % RING]) begin
            n_fail++;
            $display("FAIL %s cycle %0d pix_out=%0b expected=%0b",
                     tag, cyc, pix_out, exp_ring[cyc % RING]);
        end
        exp_ring[cyc % RING] = 1'b0;
        fetch_strobe = stb;
        fetch_addr   = a;
        fetch_data   = d;
        vid_ctrl     = ctrl;
        if (!ctrl[0]) begin
            for (int i = 1; i <= 10; i++) exp_ring[(cyc + i) % RING] = 1'b0;
        end else if (stb && a[6]) begin
            g = glyph_model(d[7:0], ctrl[3:1]);
            for (int j = 0; j < 8; j++) exp_ring[(cyc + 2 + j) % RING] = g[7 - j];
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(input int n, input logic [3:0] ctrl, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 16'h0040, 16'h0000, ctrl, tag);
    endtask

    // A fetch followed by gap-1 idle cycles.
    task automatic fetch(input logic [15:0] a, input logic [15:0] d, input logic [3:0] ctrl,
                         input int gap, input string tag);
        tick(1'b1, a, d, ctrl, tag);
        for (int i = 1; i < gap; i++) tick(1'b0, a, 16'h0000, ctrl, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: cycles=200000 expected=finish earlier");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] ctl;
        int gap;
        void'($urandom(32'd1234));
        for (int i = 0; i < RING; i++) exp_ring[i] = 1'b0;

        // R1: dark during reset, even with a qualifying fetch on the bus.
        fetch_strobe = 1'b1; fetch_addr = 16'h0040; fetch_data = 16'h00FF; vid_ctrl = 4'h1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_tests++;
            if (pix_out !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 in reset pix_out=%0b expected=0", pix_out);
            end
        end
        fetch_strobe = 1'b0; vid_ctrl = 4'h0;
        rst_n = 1'b1;
        @(posedge clk);

        // R1: enabled but no capture yet.
        idle(10, 4'h1, "R1");

        // R3 R4 R5: single character, then dark.
        fetch(16'h0040, 16'h00A5, 4'h1, 14, "R3 R4 R5");
        fetch(16'h1FC0, 16'h0013, 4'b1011, 14, "R3 R4 R5");

        // R6: a full 40-character line, exactly 8 clocks apart.
        for (int i = 0; i < 40; i++)
            fetch(16'h0040 + 16'(i), {8'hC3, 8'(i * 7 + 1)}, 4'b1101, 8, "R6");
        idle(12, 4'b1101, "R6 R5");

        // R2: non-qualifying fetches during and after a shift.
        fetch(16'h0040, 16'h0081, 4'h1, 3, "R2");
        fetch(16'h00BF, 16'h00FF, 4'h1, 3, "R2");
        tick(1'b0, 16'hFFFF, 16'h00FF, 4'h1, "R2");
        idle(12, 4'h1, "R2");
        fetch(16'hFFBF, 16'h00FF, 4'h1, 12, "R2");

        // R7: reload mid-shift replaces the remaining bits.
        fetch(16'h0040, 16'h00F0, 4'h1, 3, "R7");
        fetch(16'h0041, 16'h000F, 4'h1, 5, "R7");
        fetch(16'h0042, 16'h0055, 4'b0111, 1, "R7");
        fetch(16'h0043, 16'h00AA, 4'b0111, 12, "R7");

        // R8: disable mid-shift, fetches while off, re-enable stays dark.
        fetch(16'h0040, 16'h00FF, 4'h1, 3, "R8");
        fetch(16'h0040, 16'h00FF, 4'h0, 4, "R8");
        fetch(16'h0040, 16'h00FF, 4'h1, 1, "R8");
        tick(1'b0, 16'h0040, 16'h0000, 4'h0, "R8");
        idle(12, 4'h1, "R8");

        // R9: high byte and other address bits change nothing.
        fetch(16'hA5C0, 16'hFF3C, 4'b0011, 8, "R9");
        fetch(16'h5A7F, 16'h003C, 4'b0011, 8, "R9");
        fetch(16'h0040, 16'h123C, 4'b0011, 12, "R9");

        // Random mix of all the above.
        for (int n = 0; n < 400; n++) begin
            ctl = {3'($urandom), ($urandom % 16) != 0};
            gap = (($urandom % 4) != 0) ? 8 : int'($urandom % 12) + 1;
            fetch({16'($urandom) & 16'hFFBF} | ((($urandom % 4) != 0) ? 16'h0040 : 16'h0000),
                  16'($urandom), ctl, gap, "R2 R3 R4 R6 R7 R8 R9 random");
        end
        idle(12, 4'h1, "R5 random tail");

        summary();
        $finish;
    end
endmodule